// File: doc/BRIEF.md
# UART Receive Queue with Error Status

This block buffers characters arriving from a UART deserializer until software reads them. Each stored entry is 12 bits wide: the received byte in the low eight bits and four per-character error flags above it. The break flag sits at entry bit 10. A break indication from the line pushes its own entry, which holds zero data and only the break flag. The queue is 16 entries deep when the FIFO-enable bit of the line-control register is set. When that bit is clear, the queue acts as a single-character holding register.

A data-register read strobe pops the entry at the head of the queue. The same read copies that entry's error flags into a receive status register, and a write to the status address clears it. The block drives receive-full and receive-empty flags within an 8-bit flag register, and a receive-level interrupt event. A one-cycle overrun pulse tells the interrupt block that a character was lost. Any write to the line-control register that flips the FIFO-enable bit flushes the queue.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the fill level is 0, `flagReg` is 0x90 (bit 7 transmit-empty = 1, bit 6 receive-full = 0, bit 5 transmit-full = 0, bit 4 receive-empty = 1, other bits 0), `rxIrq`, `overrun` and `rxStatus` are 0, `lineCtrl` is 0 (FIFO disabled) and every queue slot reads as 0.
- R2: A character push stores the entry {charErr, charData} (data in bits 7:0, errors in bits 11:8). `rdData` always shows the entry at the head slot.
- R3: A break push stores 0x400. When a character and a break arrive in the same cycle, the break entry is the one stored and `overrun` pulses.
- R4: With `lineCtrl` bit 4 set, the queue accepts pushes while it holds fewer than 16 entries. Entries come out in arrival order, and the head pointer wraps from slot 15 to slot 0.
- R5: With `lineCtrl` bit 4 clear, a push is accepted only while the queue is empty.
- R6: A push that arrives while `canAccept` is 0 is dropped. `overrun` is then high for exactly the following cycle.
- R7: The receive-full flag sets on an accepted push when the FIFO is disabled or when the level reaches 16, and clears on any data read. The receive-empty flag clears on any accepted push and sets on a data read that leaves the level at 0.
- R8: A data read pops only when the level is nonzero. A read of an empty queue leaves the level and head unchanged.
- R9: A data read loads bits 11:8 of the head entry into `rxStatus`. A status write clears `rxStatus`. When both happen in the same cycle, the load wins.
- R10: `rxIrq` sets when a push takes the level from 0 to 1 (trigger level 1) and clears when a pop takes it from 1 to 0.
- R11: A line-control write that changes bit 4 resets the level and head to 0, and any push or pop in that cycle is discarded. A write that keeps bit 4 unchanged leaves the queue untouched.
- R12: An accepted push and a pop in the same cycle leave the level unchanged and advance both the head and the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | Deserializer presents a character |
| charData | input | 8 | Received byte |
| charErr | input | 4 | Error flags for the byte (bit 2 = break) |
| breakEvt | input | 1 | Break condition detected on the line |
| dataRd | input | 1 | Data-register read strobe (pops head) |
| lineCtrlWe | input | 1 | Line-control register write strobe |
| lineCtrlWdata | input | 8 | Line-control write value (bit 4 = FIFO enable) |
| statusClrWe | input | 1 | Write strobe to the receive status address |
| rdData | output | 12 | Entry at the head slot |
| rxStatus | output | 4 | Error flags of the last popped entry |
| flagReg | output | 8 | Flag register (bit 6 rx full, bit 4 rx empty, bit 7 tx empty) |
| fillLevel | output | 5 | Number of entries held |
| canAccept | output | 1 | A push this cycle would be stored |
| rxIrq | output | 1 | Receive-level interrupt event |
| overrun | output | 1 | Pulse: a push was lost |
| lineCtrl | output | 8 | Current line-control value |

## Verification
The bench runs the main function from every head position from 0 to 15. At each position it fills the queue to 16 entries and pushes one more, then drains it past empty. This shows whether the pointer wraps correctly, whether arrival order is kept, and whether the full, empty and overrun edges land on the right entry. Single-holding mode is tried with repeated pushes against an occupied slot. Break-only, break-plus-character and simultaneous push-and-pop patterns separate the entry-format rules from the level bookkeeping. Line-control writes with and without a change of the enable bit, made while entries are held, show whether a flush happens only on an actual toggle.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int DATA_W  = 8;
  localparam int ERR_W   = 4;
  localparam int ENTRY_W = DATA_W + ERR_W;
  localparam logic [ENTRY_W-1:0] BREAK_ENTRY = ENTRY_W'(12'h400);

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic useBreak;
    logic loadStatus;
    logic clrStatus;
  } rxqStrobes_t;
endpackage

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TRIG   = 1,
  parameter int LCR_W  = 8,
  parameter int EN_BIT = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charValid,
  input  logic             breakEvt,
  input  logic             dataRd,
  input  logic             lineCtrlWe,
  input  logic [LCR_W-1:0] lineCtrlWdata,
  input  logic             statusClrWe,
  output rxqStrobes_t      strb,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] wrPtr,
  output logic [CNT_W-1:0] count,
  output logic             fullFlag,
  output logic             emptyFlag,
  output logic             irqLevel,
  output logic             overrunPulse,
  output logic             acceptNow,
  output logic [LCR_W-1:0] lineCtrl
);
  logic fifoEn, pushReq, flush, pushAcc, popDo, setIrq, clrIrq;
  logic [CNT_W-1:0] countNext;
  logic [PTR_W-1:0] rdPtrNext;
  logic [CNT_W:0]   tailSum;

  always_comb begin
    fifoEn    = lineCtrl[EN_BIT];
    pushReq   = charValid | breakEvt;
    acceptNow = fifoEn ? (count < CNT_W'(DEPTH)) : (count == '0);
    flush     = lineCtrlWe && (lineCtrlWdata[EN_BIT] != fifoEn);
    pushAcc   = pushReq && acceptNow && !flush;
    popDo     = dataRd && (count != '0) && !flush;

    tailSum = (CNT_W+1)'(rdPtr) + (CNT_W+1)'(count);
    if (tailSum >= (CNT_W+1)'(DEPTH)) tailSum = tailSum - (CNT_W+1)'(DEPTH);
    wrPtr = PTR_W'(tailSum);

    if (flush)                countNext = '0;
    else if (pushAcc && !popDo) countNext = count + 1'b1;
    else if (popDo && !pushAcc) countNext = count - 1'b1;
    else                      countNext = count;

    if (flush)      rdPtrNext = '0;
    else if (popDo) rdPtrNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    else            rdPtrNext = rdPtr;

    setIrq = pushAcc && !popDo && (count == CNT_W'(TRIG - 1));
    clrIrq = popDo && !pushAcc && (count == CNT_W'(TRIG));

    strb.push       = pushAcc;
    strb.useBreak   = breakEvt;
    strb.loadStatus = dataRd;
    strb.clrStatus  = statusClrWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count        <= '0;
      rdPtr        <= '0;
      fullFlag     <= 1'b0;
      emptyFlag    <= 1'b1;
      irqLevel     <= 1'b0;
      overrunPulse <= 1'b0;
      lineCtrl     <= '0;
    end else begin
      count <= countNext;
      rdPtr <= rdPtrNext;
      if (lineCtrlWe) lineCtrl <= lineCtrlWdata;
      if (pushAcc && (!fifoEn || countNext == CNT_W'(DEPTH))) fullFlag <= 1'b1;
      else if (dataRd)                                        fullFlag <= 1'b0;
      if (pushAcc)                             emptyFlag <= 1'b0;
      else if (dataRd && countNext == '0)      emptyFlag <= 1'b1;
      if (setIrq)      irqLevel <= 1'b1;
      else if (clrIrq) irqLevel <= 1'b0;
      overrunPulse <= pushReq && (!acceptNow || (charValid && breakEvt));
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_single_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !lineCtrl[EN_BIT] |-> count <= CNT_W'(1));
  assert_flush_R11: assert property (@(posedge clk) disable iff (!rstN)
    (lineCtrlWe && lineCtrlWdata[EN_BIT] != lineCtrl[EN_BIT]) |=> (count == '0 && rdPtr == '0));
  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLevel) |-> (count == CNT_W'(TRIG) && $past(count) == CNT_W'(TRIG - 1)));
  assert_overrun_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((charValid || breakEvt) && lineCtrl[EN_BIT] && count == CNT_W'(DEPTH)) |=> overrunPulse);
  assert_same_cycle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && dataRd && count != '0) |=> (count == $past(count)));
endmodule

// File: rtl/uart_rxq_data.sv
module uart_rxq_data
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxqStrobes_t        strb,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic [DATA_W-1:0]  charData,
  input  logic [ERR_W-1:0]   charErr,
  output logic [ENTRY_W-1:0] rdData,
  output logic [ERR_W-1:0]   rxStatus
);
  logic [ENTRY_W-1:0] slotMem [DEPTH];
  logic [ENTRY_W-1:0] newEntry;

  always_comb begin
    newEntry = strb.useBreak ? BREAK_ENTRY : {charErr, charData};
    rdData   = slotMem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slotMem[i] <= '0;
    end else if (strb.push) begin
      slotMem[wrPtr] <= newEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rxStatus <= '0;
    else if (strb.loadStatus) rxStatus <= rdData[ENTRY_W-1:DATA_W];
    else if (strb.clrStatus)  rxStatus <= '0;
  end

  assert_status_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStatus |=> rxStatus == $past(rdData[ENTRY_W-1:DATA_W]));
  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStatus && !strb.loadStatus) |=> rxStatus == '0);
  assert_break_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.useBreak) |=> slotMem[$past(wrPtr)] == BREAK_ENTRY);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TRIG   = 1,
  parameter int LCR_W  = 8,
  parameter int EN_BIT = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               charValid,
  input  logic [DATA_W-1:0]  charData,
  input  logic [ERR_W-1:0]   charErr,
  input  logic               breakEvt,
  input  logic               dataRd,
  input  logic               lineCtrlWe,
  input  logic [LCR_W-1:0]   lineCtrlWdata,
  input  logic               statusClrWe,
  output logic [ENTRY_W-1:0] rdData,
  output logic [ERR_W-1:0]   rxStatus,
  output logic [7:0]         flagReg,
  output logic [CNT_W-1:0]   fillLevel,
  output logic               canAccept,
  output logic               rxIrq,
  output logic               overrun,
  output logic [LCR_W-1:0]   lineCtrl
);
  localparam int TXE_BIT = 7;
  localparam int RXF_BIT = 6;
  localparam int RXE_BIT = 4;

  rxqStrobes_t      strb;
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic             fullFlag, emptyFlag;

  uart_rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG), .LCR_W(LCR_W), .EN_BIT(EN_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .charValid(charValid), .breakEvt(breakEvt),
    .dataRd(dataRd), .lineCtrlWe(lineCtrlWe), .lineCtrlWdata(lineCtrlWdata),
    .statusClrWe(statusClrWe), .strb(strb), .rdPtr(rdPtr), .wrPtr(wrPtr),
    .count(fillLevel), .fullFlag(fullFlag), .emptyFlag(emptyFlag),
    .irqLevel(rxIrq), .overrunPulse(overrun), .acceptNow(canAccept),
    .lineCtrl(lineCtrl)
  );

  uart_rxq_data #(.DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .charData(charData), .charErr(charErr), .rdData(rdData), .rxStatus(rxStatus)
  );

  always_comb begin
    flagReg          = '0;
    flagReg[TXE_BIT] = 1'b1;
    flagReg[RXF_BIT] = fullFlag;
    flagReg[RXE_BIT] = emptyFlag;
  end
endmodule

// File: tb/uart_rx_queue_tb_top.sv
`timescale 1ns/1ps
module uart_rx_queue_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic charValid = 0, breakEvt = 0, dataRd = 0, lineCtrlWe = 0, statusClrWe = 0;
  logic [7:0] charData = 0, lineCtrlWdata = 0;
  logic [3:0] charErr = 0;
  logic [11:0] rdData;
  logic [3:0] rxStatus;
  logic [7:0] flagReg, lineCtrl;
  logic [4:0] fillLevel;
  logic canAccept, rxIrq, overrun;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench-side expectation state
  int mMem[16];
  int mHead = 0, mCnt = 0, mStat = 0, mLcr = 0;
  bit mFull = 0, mEmpty = 1, mIrq = 0, mOvr = 0;

  always #4 clk = ~clk;

  uart_rx_queue dut_i (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .charErr(charErr), .breakEvt(breakEvt), .dataRd(dataRd),
    .lineCtrlWe(lineCtrlWe), .lineCtrlWdata(lineCtrlWdata),
    .statusClrWe(statusClrWe), .rdData(rdData), .rxStatus(rxStatus),
    .flagReg(flagReg), .fillLevel(fillLevel), .canAccept(canAccept),
    .rxIrq(rxIrq), .overrun(overrun), .lineCtrl(lineCtrl)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    bit en;
    en = mLcr[4];
    chk(tag, "fillLevel", int'(fillLevel), mCnt);
    chk(tag, "flagReg", int'(flagReg), 8'h80 | (mFull ? 8'h40 : 0) | (mEmpty ? 8'h10 : 0));
    chk(tag, "rxIrq", int'(rxIrq), int'(mIrq));
    chk(tag, "rxStatus", int'(rxStatus), mStat);
    chk(tag, "overrun", int'(overrun), int'(mOvr));
    chk(tag, "canAccept", int'(canAccept), en ? int'(mCnt < 16) : int'(mCnt == 0));
    chk(tag, "rdData", int'(rdData), mMem[mHead]);
    chk(tag, "lineCtrl", int'(lineCtrl), mLcr);
  endtask

  task automatic step(input string tag, input bit cv, input int cd, input int ce,
                      input bit brk, input bit rd, input bit lcWe, input int lcVal,
                      input bit sClr);
    bit en, accept, flush, pushAcc, popDo, pushReq;
    int entry, cntN, wrIdx;
    charValid = cv; charData = 8'(cd); charErr = 4'(ce); breakEvt = brk;
    dataRd = rd; lineCtrlWe = lcWe; lineCtrlWdata = 8'(lcVal); statusClrWe = sClr;
    en      = mLcr[4];
    pushReq = cv || brk;
    accept  = en ? (mCnt < 16) : (mCnt == 0);
    flush   = lcWe && (lcVal[4] != en);
    pushAcc = pushReq && accept && !flush;
    popDo   = rd && mCnt > 0 && !flush;
    entry   = brk ? 12'h400 : ((ce & 15) << 8) | (cd & 255);
    wrIdx   = (mHead + mCnt) % 16;
    cntN    = flush ? 0 : mCnt + int'(pushAcc) - int'(popDo);
    @(posedge clk);
    #1;
    charValid = 0; breakEvt = 0; dataRd = 0; lineCtrlWe = 0; statusClrWe = 0;
    if (rd) mStat = (mMem[mHead] >> 8) & 15;
    else if (sClr) mStat = 0;
    if (pushAcc) mMem[wrIdx] = entry;
    if (pushAcc && (!en || cntN == 16)) mFull = 1;
    else if (rd) mFull = 0;
    if (pushAcc) mEmpty = 0;
    else if (rd && cntN == 0) mEmpty = 1;
    if (pushAcc && !popDo && mCnt == 0) mIrq = 1;
    else if (popDo && !pushAcc && mCnt == 1) mIrq = 0;
    mOvr = pushReq && (!accept || (cv && brk));
    if (flush) mHead = 0;
    else if (popDo) mHead = (mHead + 1) % 16;
    mCnt = cntN;
    if (lcWe) mLcr = lcVal & 255;
    compareAll(tag);
  endtask

  task automatic pushC(input string tag, input int d, input int e);
    step(tag, 1, d, e, 0, 0, 0, 0, 0);
  endtask
  task automatic rdP(input string tag);
    step(tag, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mMem[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #2 compareAll("R1");

    // single-character holding mode
    pushC("R2", 8'h5a, 4'h3);
    pushC("R5", 8'h11, 4'h0);
    pushC("R6", 8'h22, 4'h1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
    rdP("R9");
    rdP("R8");
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R3", 0, 0, 0, 1, 0, 0, 0, 0);
    rdP("R3");
    step("R3", 1, 8'h77, 4'h8, 1, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 0, 0, 1);
    step("R7", 1, 8'h99, 4'h2, 0, 1, 0, 0, 0);
    rdP("R10");

    // enable FIFO mode (toggle)
    step("R11", 0, 0, 0, 0, 0, 1, 8'h10, 0);

    for (int off = 0; off < 16; off++) begin
      for (int k = 0; k < off; k++) begin
        pushC("R4", k, 0);
        rdP("R4");
      end
      for (int i = 0; i < 17; i++)
        pushC(i == 16 ? "R6" : (i == 15 ? "R7" : "R4"),
              ((off * 16 + i) * 7 + 3) & 255, (i + off) & 15);
      rdP("R7");
      step("R12", 1, off, 4'h5, 0, 1, 0, 0, 0);
      for (int j = 0; j < 17; j++)
        rdP(j == 16 ? "R8" : (j == 15 ? "R10" : "R4"));
    end

    // same-bit rewrite keeps contents, toggle flushes
    pushC("R11", 8'h31, 1);
    pushC("R11", 8'h32, 2);
    step("R11", 0, 0, 0, 0, 0, 1, 8'h13, 0);
    step("R11", 1, 8'h33, 3, 0, 1, 1, 8'h03, 0);
    pushC("R5", 8'h44, 4);
    pushC("R5", 8'h45, 5);
    step("R12", 1, 8'h46, 6, 0, 1, 0, 0, 0);
    rdP("R10");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule